// File: doc/BRIEF.md
# Converter Power-Up/Down Fade Sequencer

This block governs the output of an audio converter around reset and power-down. It watches a flag that reports whether the master, bit and frame clocks are consistent with one another, a power-down request, and a strobe that marks each sample period. From these it produces an internal reset for the converter core, an enable for the data output, and a fade gain. The fade gain is applied to the outgoing samples, so that the output never jumps between silence and full level.

The sequencer counts sample periods to time each phase. It works through five named states. `ST_RESET` holds the core in reset. `ST_WAIT` is a silent initial delay of `WAIT_SAMPLES` sample periods with the output enabled. `ST_RAMP_UP` is a linear fade-in of `RAMP_SAMPLES` periods. `ST_RUN` is normal operation at unity gain. `ST_RAMP_DOWN` is a linear fade-out.

The transitions are as follows:
- reset→wait when clocks are consistent and no power-down is requested;
- wait→ramp-up after the delay;
- ramp-up→run at unity;
- ramp-up→ramp-down and run→ramp-down on a power-down request;
- ramp-down→reset when the gain reaches zero;
- wait→reset on a power-down request;
- any state→reset at once on loss of clock consistency.

Top module: `cvt_fade_seq`

## Requirements
- R1: While `rst_n` is low, `int_rst` is 1, `dout_en` is 0, `fade_gain` is 0 and `dout` is 0.
- R2: On any clock edge where `sync_ok` is 0, the block enters the reset state, with no fade-out. From the next clock, `int_rst` is 1, `dout_en` is 0, `fade_gain` is 0 and `dout` is 0.
- R3: In the reset state with `sync_ok`=1 and `pwr_down`=0, the next clock gives `int_rst`=0 and `dout_en`=1. The gain then stays 0 for exactly `WAIT_SAMPLES` strobes, and the fade-in begins on the edge of the last of them.
- R4: `fade_gain` changes by at most one step per clock, and only on clocks where `smp_stb` is 1 (apart from the reset to 0 of R2).
- R5: During the fade-in, each strobe raises `fade_gain` by 1, from 0 to `RAMP_SAMPLES` (unity). On reaching unity the block enters normal operation.
- R6: `dout` = (din × fade_gain) / `RAMP_SAMPLES`. Here `din` and `dout` are two's complement and the quotient is truncated toward zero. At unity gain `dout` equals `din`.
- R7: A `pwr_down`=1 during fade-in or normal operation starts a fade-out from the current gain. Each following strobe lowers the gain by 1, whatever `pwr_down` does later. The clock on which the gain reaches 0 returns the block to the reset state (`int_rst`=1, `dout_en`=0).
- R8: `pwr_down`=1 during the initial delay returns the block to the reset state on the next clock. While `pwr_down` stays 1, the block remains in the reset state.
- R9: Every exit from the reset state restarts the full initial delay and fade-in; no count is kept from an earlier pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_ok | input | 1 | 1 while the converter clocks are consistent |
| pwr_down | input | 1 | Power-down / disable request |
| smp_stb | input | 1 | One-clock pulse per sample period |
| din | input | DATA_W | Converted sample, two's complement |
| int_rst | output | 1 | Internal reset to the converter core |
| dout_en | output | 1 | Data output enable |
| fade_gain | output | GAIN_W | Fade gain, 0 to RAMP_SAMPLES (unity) |
| dout | output | DATA_W | Faded sample, two's complement |

## Verification
The hardest situation to reach is a power-down request that lands mid-fade-in, or exactly on the first fade-in edge while the gain is still zero. Each case sits behind a full initial delay and a partial ramp. The stimulus drives complete power-up passes with the strobe both on every clock and on alternate clocks. It asserts `pwr_down` after a counted number of ramp strobes, and once on the very step that enters the fade-in. A behavioural reference model compares every output on every clock.

// File: rtl/cvt_fade_seq_pkg.sv
package cvt_fade_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_WAIT      = 3'd1,
        ST_RAMP_UP   = 3'd2,
        ST_RUN       = 3'd3,
        ST_RAMP_DOWN = 3'd4
    } seq_state_t;

endpackage

// File: rtl/cvt_fade_seq_timer.sv
module cvt_fade_seq_timer #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_V);

    // R3: the delay counter never runs past its last count
    a_r3_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_V);

endmodule

// File: rtl/cvt_fade_seq_ramp.sv
module cvt_fade_seq_ramp #(
    parameter int RAMP_SAMPLES = 1936,
    parameter int GAIN_W       = $clog2(RAMP_SAMPLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              dec,
    output logic [GAIN_W-1:0] gain,
    output logic              at_zero,
    output logic              at_one,
    output logic              at_top_m1
);
    localparam logic [GAIN_W-1:0] TOP = GAIN_W'(RAMP_SAMPLES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= '0;
        end else if (clr) begin
            gain <= '0;
        end else if (inc) begin
            gain <= gain + 1'b1;
        end else if (dec) begin
            gain <= gain - 1'b1;
        end
    end

    assign at_zero   = (gain == '0);
    assign at_one    = (gain == GAIN_W'(1));
    assign at_top_m1 = (gain == GAIN_W'(RAMP_SAMPLES - 1));

    // R5: gain never exceeds unity
    a_r5_gain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= TOP);

    // R4: a change of gain is a single step, or a drop to zero
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gain != $past(gain)) |->
        (gain == $past(gain) + 1'b1 || gain + 1'b1 == $past(gain) || gain == '0));

endmodule

// File: rtl/cvt_fade_seq_scale.sv
module cvt_fade_seq_scale #(
    parameter int DATA_W       = 16,
    parameter int RAMP_SAMPLES = 1936,
    parameter int GAIN_W       = $clog2(RAMP_SAMPLES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] din,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] dout
);
    localparam int PW = DATA_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] DIV = PW'(RAMP_SAMPLES);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;

    always_comb begin
        prod = $signed(PW'(din)) * $signed(PW'({1'b0, gain}));
        quot = prod / DIV;
        dout = quot[DATA_W-1:0];
    end

    // R6: the scaled sample always fits the output width
    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        quot == $signed(PW'(dout)));

endmodule

// File: rtl/cvt_fade_seq_fsm.sv
module cvt_fade_seq_fsm
    import cvt_fade_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_ok,
    input  logic pwr_down,
    input  logic smp_stb,
    input  logic wait_last,
    input  logic gain_zero,
    input  logic gain_one,
    input  logic gain_top_m1,
    output logic wait_clr,
    output logic wait_inc,
    output logic gain_clr,
    output logic gain_inc,
    output logic gain_dec,
    output logic int_rst,
    output logic dout_en
);
    seq_state_t st;
    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_RESET;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt      = st;
        wait_clr = 1'b0;
        wait_inc = 1'b0;
        gain_clr = 1'b0;
        gain_inc = 1'b0;
        gain_dec = 1'b0;
        unique case (st)
            ST_RESET: begin
                wait_clr = 1'b1;
                gain_clr = 1'b1;
                if (sync_ok && !pwr_down) begin
                    nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!sync_ok || pwr_down) begin
                    nxt      = ST_RESET;
                    wait_clr = 1'b1;
                end else if (smp_stb) begin
                    if (wait_last) begin
                        nxt      = ST_RAMP_UP;
                        wait_clr = 1'b1;
                    end else begin
                        wait_inc = 1'b1;
                    end
                end
            end
            ST_RAMP_UP: begin
                if (!sync_ok) begin
                    nxt      = ST_RESET;
                    gain_clr = 1'b1;
                end else if (pwr_down) begin
                    nxt = ST_RAMP_DOWN;
                end else if (smp_stb) begin
                    gain_inc = 1'b1;
                    if (gain_top_m1) begin
                        nxt = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!sync_ok) begin
                    nxt      = ST_RESET;
                    gain_clr = 1'b1;
                end else if (pwr_down) begin
                    nxt = ST_RAMP_DOWN;
                end
            end
            ST_RAMP_DOWN: begin
                if (!sync_ok) begin
                    nxt      = ST_RESET;
                    gain_clr = 1'b1;
                end else if (gain_zero) begin
                    nxt = ST_RESET;
                end else if (smp_stb) begin
                    gain_dec = 1'b1;
                    if (gain_one) begin
                        nxt = ST_RESET;
                    end
                end
            end
            default: begin
                nxt      = ST_RESET;
                gain_clr = 1'b1;
                wait_clr = 1'b1;
            end
        endcase
    end

    always_comb begin
        int_rst = (st == ST_RESET);
        dout_en = (st != ST_RESET);
    end

    // R7: a fade-out only ends by returning to reset
    a_r7_fade_out_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMP_DOWN) |=> (st == ST_RAMP_DOWN || st == ST_RESET));

    // R3: the fade-in is entered only from the initial delay
    a_r3_wait_before_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMP_UP && $past(st) != ST_RAMP_UP) |-> ($past(st) == ST_WAIT));

    // R8: a power-down seen in reset keeps the block in reset
    a_r8_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESET && pwr_down) |=> (st == ST_RESET));

endmodule

// File: rtl/cvt_fade_seq.sv
module cvt_fade_seq #(
    parameter int DATA_W       = 16,
    parameter int WAIT_SAMPLES = 2048,
    parameter int RAMP_SAMPLES = 1936,
    parameter int GAIN_W       = $clog2(RAMP_SAMPLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_ok,
    input  logic              pwr_down,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] din,
    output logic              int_rst,
    output logic              dout_en,
    output logic [GAIN_W-1:0] fade_gain,
    output logic [DATA_W-1:0] dout
);
    logic wait_clr, wait_inc, wait_last;
    logic gain_clr, gain_inc, gain_dec;
    logic gain_zero, gain_one, gain_top_m1;
    logic signed [DATA_W-1:0] scaled;

    cvt_fade_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_ok     (sync_ok),
        .pwr_down    (pwr_down),
        .smp_stb     (smp_stb),
        .wait_last   (wait_last),
        .gain_zero   (gain_zero),
        .gain_one    (gain_one),
        .gain_top_m1 (gain_top_m1),
        .wait_clr    (wait_clr),
        .wait_inc    (wait_inc),
        .gain_clr    (gain_clr),
        .gain_inc    (gain_inc),
        .gain_dec    (gain_dec),
        .int_rst     (int_rst),
        .dout_en     (dout_en)
    );

    cvt_fade_seq_timer #(.LIMIT(WAIT_SAMPLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .inc   (wait_inc),
        .last  (wait_last)
    );

    cvt_fade_seq_ramp #(.RAMP_SAMPLES(RAMP_SAMPLES), .GAIN_W(GAIN_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (gain_clr),
        .inc       (gain_inc),
        .dec       (gain_dec),
        .gain      (fade_gain),
        .at_zero   (gain_zero),
        .at_one    (gain_one),
        .at_top_m1 (gain_top_m1)
    );

    cvt_fade_seq_scale #(
        .DATA_W(DATA_W), .RAMP_SAMPLES(RAMP_SAMPLES), .GAIN_W(GAIN_W)
    ) u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ($signed(din)),
        .gain  (fade_gain),
        .dout  (scaled)
    );

    assign dout = scaled;

    // R2: loss of clock consistency forces reset on the next clock
    a_r2_sync_loss_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok |=> (int_rst && fade_gain == '0));

    // R4: without a strobe the gain holds while clocks are consistent
    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && !smp_stb) |=> $stable(fade_gain));

    // R6: unity gain passes the sample unchanged
    a_r6_unity_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_gain == GAIN_W'(RAMP_SAMPLES)) |-> (dout == din));

    // R1: in reset the output is silent and disabled
    a_r1_reset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> (!dout_en && fade_gain == '0 && dout == '0));

endmodule

// File: tb/test_cvt_fade_seq.sv
`timescale 1ns/1ps
module test_cvt_fade_seq;
    localparam int DW     = 16;
    localparam int WAIT_N = 2048;
    localparam int RAMP_N = 1936;
    localparam int GW     = $clog2(RAMP_N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_ok = 1'b0;
    logic          pwr_down = 1'b0;
    logic          smp_stb = 1'b0;
    logic [DW-1:0] din = '0;
    logic          int_rst;
    logic          dout_en;
    logic [GW-1:0] fade_gain;
    logic [DW-1:0] dout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model: 0 reset, 1 delay, 2 fade-in, 3 run, 4 fade-out
    int m_ph = 0;
    int m_cnt = 0;
    int m_gain = 0;

    always #2.5 clk = ~clk;

    cvt_fade_seq #(.DATA_W(DW), .WAIT_SAMPLES(WAIT_N), .RAMP_SAMPLES(RAMP_N)) i_cvt_fade_seq (
        .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .pwr_down(pwr_down),
        .smp_stb(smp_stb), .din(din), .int_rst(int_rst), .dout_en(dout_en),
        .fade_gain(fade_gain), .dout(dout)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_dout();
        return (int'($signed(din)) * m_gain) / RAMP_N;
    endfunction

    task automatic compare_all(input string tag);
        check(int_rst == (m_ph == 0), tag, "int_rst", int'(int_rst), int'(m_ph == 0));
        check(dout_en == (m_ph != 0), tag, "dout_en", int'(dout_en), int'(m_ph != 0));
        check(int'(fade_gain) == m_gain, tag, "fade_gain", int'(fade_gain), m_gain);
        check(int'($signed(dout)) == exp_dout(), tag, "dout",
              int'($signed(dout)), exp_dout());
    endtask

    task automatic model_edge(input bit s, input bit p, input bit b);
        case (m_ph)
            0: if (s && !p) begin m_ph = 1; m_cnt = 0; end
            1: if (!s || p) m_ph = 0;
               else if (b) begin
                   if (m_cnt == WAIT_N - 1) begin m_ph = 2; m_cnt = 0; end
                   else m_cnt++;
               end
            2: if (!s) begin m_ph = 0; m_gain = 0; end
               else if (p) m_ph = 4;
               else if (b) begin
                   m_gain++;
                   if (m_gain == RAMP_N) m_ph = 3;
               end
            3: if (!s) begin m_ph = 0; m_gain = 0; end
               else if (p) m_ph = 4;
            default: if (!s) begin m_ph = 0; m_gain = 0; end
               else if (m_gain == 0) m_ph = 0;
               else if (b) begin
                   m_gain--;
                   if (m_gain == 0) m_ph = 0;
               end
        endcase
    endtask

    // one clock: drive, compare against model, advance model, wait for next negedge
    task automatic step(input bit s, input bit p, input bit b, input string tag);
        sync_ok  = s;
        pwr_down = p;
        smp_stb  = b;
        din      = DW'($urandom);
        #1;
        compare_all(tag);
        model_edge(s, p, b);
        @(negedge clk);
    endtask

    task automatic run(input int n, input bit s, input bit p, input int stride,
                       input string tag);
        for (int i = 0; i < n; i++) begin
            step(s, p, (i % stride) == 0, tag);
        end
    endtask

    task automatic full_rise(input string tag);
        run(WAIT_N + 1, 1'b1, 1'b0, 1, tag);
        run(RAMP_N, 1'b1, 1'b0, 1, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1 reset state
        check(int_rst == 1'b1, "R1", "int_rst", int'(int_rst), 1);
        check(dout_en == 1'b0, "R1", "dout_en", int'(dout_en), 0);
        check(fade_gain == '0, "R1", "fade_gain", int'(fade_gain), 0);
        check(dout == '0, "R1", "dout", int'(dout), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 no sync: stays in reset
        run(20, 1'b0, 1'b0, 1, "R2");
        check(int_rst == 1'b1, "R2", "int_rst held", int'(int_rst), 1);

        // R3 release and silent delay
        step(1'b1, 1'b0, 1'b1, "R3");
        check(int_rst == 1'b0 && dout_en == 1'b1, "R3", "released", int'(dout_en), 1);
        run(WAIT_N - 1, 1'b1, 1'b0, 1, "R3");
        check(fade_gain == '0, "R3", "gain at end of delay", int'(fade_gain), 0);
        step(1'b1, 1'b0, 1'b1, "R3");

        // R4 strobe on alternate clocks
        run(200, 1'b1, 1'b0, 2, "R4 R6");
        check(int'(fade_gain) == 100, "R4", "gain after 100 strobes", int'(fade_gain), 100);

        // R5 complete fade-in
        run(RAMP_N - 100, 1'b1, 1'b0, 1, "R5 R6");
        check(int'(fade_gain) == RAMP_N, "R5", "unity", int'(fade_gain), RAMP_N);
        run(30, 1'b1, 1'b0, 1, "R6");
        check(dout == din, "R6", "passthrough", int'($signed(dout)), int'($signed(din)));

        // R7 fade-out from unity; request released after one clock
        step(1'b1, 1'b1, 1'b0, "R7");
        run(RAMP_N - 1, 1'b1, 1'b0, 1, "R7");
        check(int'(fade_gain) == 1 && int_rst == 1'b0, "R7", "gain one step from end",
              int'(fade_gain), 1);
        step(1'b1, 1'b0, 1'b1, "R7");
        check(int_rst == 1'b1 && dout_en == 1'b0, "R7", "back in reset", int'(int_rst), 1);

        // R9 restart with full delay, then disable mid fade-in
        run(WAIT_N + 1, 1'b1, 1'b0, 1, "R9");
        check(fade_gain == '0 && dout_en == 1'b1, "R9", "fresh fade-in start",
              int'(fade_gain), 0);
        run(500, 1'b1, 1'b0, 1, "R5");
        step(1'b1, 1'b1, 1'b1, "R7");
        check(int'(fade_gain) == 500, "R7", "fade-out starts at current gain",
              int'(fade_gain), 500);
        run(100, 1'b1, 1'b0, 1, "R7");
        check(int'(fade_gain) == 400, "R7", "fade-out progress", int'(fade_gain), 400);

        // R2 sync loss mid fade-out: immediate reset
        step(1'b0, 1'b0, 1'b1, "R2");
        check(int_rst == 1'b1 && fade_gain == '0, "R2", "no fade-out on loss",
              int'(fade_gain), 0);

        // R8 power-down held in reset, then during delay
        run(10, 1'b1, 1'b1, 1, "R8");
        check(int_rst == 1'b1, "R8", "held by request", int'(int_rst), 1);
        run(100, 1'b1, 1'b0, 1, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        check(int_rst == 1'b1, "R8", "request during delay", int'(int_rst), 1);

        // R2 sync loss during delay
        run(50, 1'b1, 1'b0, 1, "R2");
        step(1'b0, 1'b0, 1'b1, "R2");
        check(int_rst == 1'b1, "R2", "loss during delay", int'(int_rst), 1);

        // R7 request on the first fade-in clock (gain zero)
        run(WAIT_N + 1, 1'b1, 1'b0, 1, "R9");
        step(1'b1, 1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b1, "R7");
        check(int_rst == 1'b1, "R7", "zero-gain fade-out ends at once", int'(int_rst), 1);

        // R2 sync loss during normal operation
        full_rise("R5");
        check(int'(fade_gain) == RAMP_N, "R5", "unity again", int'(fade_gain), RAMP_N);
        step(1'b0, 1'b0, 1'b0, "R2");
        check(int_rst == 1'b1 && dout == '0, "R2", "loss in normal", int'(int_rst), 1);
        run(5, 1'b0, 1'b0, 1, "R2");

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule